// File: doc/BRIEF.md
# Ring Replicated-Memory Node Controller

This block is the per-node logic of a one-way ring of nodes that keep a shared memory image identical. A host write at a node updates that node's memory through a write port and is queued for transmission, tagged with the node's identifier. The transmitter cuts the queue into packets of 1 to 16 contiguous 32-bit words (4 to 64 bytes) and sends them to the next node.

Each node takes in packets from its upstream neighbour. A packet that arrives without error and that another node sent is written to local memory at the address it carries. It is also pushed back into the transmit queue, so it travels on around the ring. A packet that has come all the way back to the node that sent it is dropped from the ring, and a sticky flag records that this happened. The node sends nothing while its receive link has no signal or is out of sync.

Top module: `ring_mem_node`

## Requirements
- R1: After reset, user_stat is 1, own_data_seen is 0, tx_valid is 0, and host_ready and rx_ready are both 1.
- R2: A host write is accepted in a cycle where host_valid and host_ready are both high. In that same cycle, mem_we is high with mem_addr = host_addr and mem_data = host_data. The word is queued for sending with origin equal to node_id.
- R3: Transmitted packets hold runs of queued words that share one origin and have consecutive word addresses. A packet holds at most 16 words and is cut at the 16th word. On the first beat tx_sop is high and tx_len carries the byte count (4 × words, from 4 to 64). On the last beat tx_eop is high. Every beat carries tx_addr and tx_origin for its own word. A beat moves when tx_valid and tx_ready are both high.
- R4: A received packet is dropped if rx_err is high on its eop beat, or if it has more than 16 beats. A dropped packet causes no memory write and no transmission.
- R5: A good received packet whose origin differs from node_id is written to memory word by word, starting at rx_addr, in consecutive cycles. The same words are sent on with their origin and addresses unchanged.
- R6: A good received packet whose origin equals node_id causes no memory write and no transmission.
- R7: own_data_seen goes high after a good packet of the node's own origin is received. It stays high until reset.
- R8: tx_valid stays 0 whenever link_present or link_sync is low. Queued words are kept and sent once the link recovers.
- R9: While a received packet is being written and forwarded, host_ready is 0. The forwarded words reach memory and the queue ahead of any host write that is waiting.
- R10: When the transmit queue (32 words) is full, host_ready is 0 and the waiting host write is held without loss.
- R11: A cycle with user_stat_we high loads user_stat_d into user_stat at the next clock edge. When user_stat_we is low, user_stat keeps its value.
- R12: signal_detect equals link_present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 8 | Static identifier of this node |
| host_valid | input | 1 | Host write request |
| host_ready | output | 1 | Host write can be taken |
| host_addr | input | 16 | Host word address |
| host_data | input | 32 | Host write data |
| mem_we | output | 1 | Local memory write strobe |
| mem_addr | output | 16 | Local memory word address |
| mem_data | output | 32 | Local memory write data |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat can be taken |
| rx_sop | input | 1 | First beat of a received packet |
| rx_eop | input | 1 | Last beat of a received packet |
| rx_err | input | 1 | Packet failed its check (sampled at eop) |
| rx_origin | input | 8 | Origin node of received packet (sampled at sop) |
| rx_addr | input | 16 | Start word address (sampled at sop) |
| rx_data | input | 32 | Received data word |
| link_present | input | 1 | Receiver sees a signal |
| link_sync | input | 1 | Receiver is synchronised |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Downstream takes the beat |
| tx_sop | output | 1 | First beat of a transmitted packet |
| tx_eop | output | 1 | Last beat of a transmitted packet |
| tx_origin | output | 8 | Origin of the beat's word |
| tx_addr | output | 16 | Word address of the beat |
| tx_len | output | 7 | Packet byte count, valid on first beat |
| tx_data | output | 32 | Transmitted data word |
| user_stat_we | input | 1 | Write strobe for user status |
| user_stat_d | input | 1 | New user status value |
| user_stat | output | 1 | User status indicator |
| signal_detect | output | 1 | Signal-detect indicator |
| own_data_seen | output | 1 | Sticky flag: own data came back |

## Verification
The bench tries every packet size from 1 to 20 queued host words and every received size from 1 to 16. A packet splitter that misplaces the 16-word cut, or a length field off by one word, shows up as the wrong sop, eop or tx_len beats. It sends gapped addresses and mixed origins to expose a design that merges runs it should keep apart. It sends error, over-length and self-originated packets, which a faulty design would write to memory or keep circulating. It also fills the queue, drops the link, and overlaps a host write with a forward, so a design that loses words, transmits without sync, or lets the host jump ahead of ring traffic fails the beat-by-beat comparison.

// File: rtl/ring_mem_node.sv
module ring_mem_node #(
  parameter int NODE_W    = 8,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 16,
  parameter int DEPTH     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node_id,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic              rx_err,
  input  logic [NODE_W-1:0] rx_origin,
  input  logic [AW-1:0]     rx_addr,
  input  logic [DW-1:0]     rx_data,
  input  logic              link_present,
  input  logic              link_sync,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [NODE_W-1:0] tx_origin,
  output logic [AW-1:0]     tx_addr,
  output logic [$clog2(MAX_WORDS*4):0] tx_len,
  output logic [DW-1:0]     tx_data,
  input  logic              user_stat_we,
  input  logic              user_stat_d,
  output logic              user_stat,
  output logic              signal_detect,
  output logic              own_data_seen
);
  localparam int PW = $clog2(DEPTH);
  localparam int BI = $clog2(MAX_WORDS);
  localparam int CW = BI + 1;
  localparam int LW = $clog2(MAX_WORDS*4) + 1;

  // transmit queue
  logic [NODE_W-1:0] q_org  [DEPTH];
  logic [AW-1:0]     q_addr [DEPTH];
  logic [DW-1:0]     q_data [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [PW:0]       count;
  logic              full, push, push_fwd, push_host, pop, link_ok;
  logic [NODE_W-1:0] p_org;
  logic [AW-1:0]     p_addr;
  logic [DW-1:0]     p_data;

  // receive buffer and drain
  logic [DW-1:0]     rbuf [MAX_WORDS];
  logic [NODE_W-1:0] b_org;
  logic [AW-1:0]     b_addr;
  logic              in_rx, ovf, drain;
  logic [CW-1:0]     wi, buf_n, rx_idx;
  logic [BI-1:0]     ptr;
  logic              rx_take, rx_ovf_nxt, rx_good;
  logic [NODE_W-1:0] rx_org_cur;

  // packetiser
  logic              in_pkt, go_scan;
  logic [CW-1:0]     rem, run;
  logic              stat_q, own_q;

  assign link_ok       = link_present && link_sync;
  assign signal_detect = link_present;
  assign user_stat     = stat_q;
  assign own_data_seen = own_q;

  assign full      = (count == (PW+1)'(DEPTH));
  assign push_fwd  = drain && !full;
  assign host_ready = !full && !drain;
  assign push_host = host_valid && host_ready;
  assign push      = push_fwd || push_host;
  assign p_org     = push_fwd ? b_org : node_id;
  assign p_addr    = push_fwd ? b_addr + AW'(ptr) : host_addr;
  assign p_data    = push_fwd ? rbuf[ptr] : host_data;

  assign mem_we   = push;
  assign mem_addr = p_addr;
  assign mem_data = p_data;

  always_comb begin
    go_scan = 1'b1;
    run = CW'(1);
    for (int i = 1; i < MAX_WORDS; i++) begin
      if (go_scan && (i < int'(count)) &&
          q_org[rd_ptr + PW'(i)] == q_org[rd_ptr] &&
          q_addr[rd_ptr + PW'(i)] == q_addr[rd_ptr] + AW'(i))
        run = CW'(i + 1);
      else
        go_scan = 1'b0;
    end
  end

  assign tx_valid  = link_ok && (count != '0);
  assign tx_sop    = !in_pkt;
  assign tx_eop    = in_pkt ? (rem == CW'(1)) : (run == CW'(1));
  assign tx_len    = in_pkt ? '0 : LW'({run, 2'b00});
  assign tx_origin = q_org[rd_ptr];
  assign tx_addr   = q_addr[rd_ptr];
  assign tx_data   = q_data[rd_ptr];
  assign pop       = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (push) begin
      q_org[wr_ptr]  <= p_org;
      q_addr[wr_ptr] <= p_addr;
      q_data[wr_ptr] <= p_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      in_pkt <= 1'b0;
      rem    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
      if (pop) begin
        if (!in_pkt) begin
          if (run != CW'(1)) begin
            in_pkt <= 1'b1;
            rem    <= run - CW'(1);
          end
        end else begin
          rem <= rem - CW'(1);
          if (rem == CW'(1)) in_pkt <= 1'b0;
        end
      end
    end
  end

  assign rx_ready   = !drain;
  assign rx_take    = rx_valid && rx_ready && (rx_sop || in_rx);
  assign rx_idx     = rx_sop ? '0 : wi;
  assign rx_ovf_nxt = (!rx_sop && ovf) || (rx_idx >= CW'(MAX_WORDS));
  assign rx_org_cur = rx_sop ? rx_origin : b_org;
  assign rx_good    = rx_take && rx_eop && !rx_err && !rx_ovf_nxt;

  always_ff @(posedge clk) begin
    if (rx_take && !rx_idx[BI]) rbuf[rx_idx[BI-1:0]] <= rx_data;
    if (rx_take && rx_sop) begin
      b_org  <= rx_origin;
      b_addr <= rx_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_rx  <= 1'b0;
      ovf    <= 1'b0;
      wi     <= '0;
      drain  <= 1'b0;
      buf_n  <= '0;
      ptr    <= '0;
      own_q  <= 1'b0;
      stat_q <= 1'b1;
    end else begin
      if (user_stat_we) stat_q <= user_stat_d;
      if (rx_take) begin
        ovf   <= rx_ovf_nxt;
        wi    <= rx_idx[BI] ? rx_idx : rx_idx + CW'(1);
        in_rx <= !rx_eop;
      end
      if (rx_good) begin
        if (rx_org_cur == node_id) own_q <= 1'b1;
        else begin
          drain <= 1'b1;
          buf_n <= rx_idx + CW'(1);
          ptr   <= '0;
        end
      end
      if (push_fwd) begin
        ptr <= ptr + BI'(1);
        if (CW'(ptr) == buf_n - CW'(1)) drain <= 1'b0;
      end
    end
  end

  p_no_tx_link_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_present || !link_sync) |-> !tx_valid);

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> (tx_len >= LW'(4) && tx_len <= LW'(MAX_WORDS*4) && tx_len[1:0] == 2'b00));

  p_own_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    own_data_seen |=> own_data_seen);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !host_ready);

  p_mem_queued_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (count == $past(count) + (PW+1)'(1) - (PW+1)'($past(pop))));

  p_err_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_eop && rx_err && !drain) |=> !drain);
endmodule

// File: tb/ring_mem_node_test.sv
module ring_mem_node_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MY_ID = 8'd5;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_ready;
  logic [15:0] host_addr = 0;
  logic [31:0] host_data = 0;
  logic mem_we; logic [15:0] mem_addr; logic [31:0] mem_data;
  logic rx_valid = 0, rx_ready, rx_sop = 0, rx_eop = 0, rx_err = 0;
  logic [7:0] rx_origin = 0; logic [15:0] rx_addr = 0; logic [31:0] rx_data = 0;
  logic link_present = 1, link_sync = 1;
  logic tx_valid, tx_ready = 0, tx_sop, tx_eop;
  logic [7:0] tx_origin; logic [15:0] tx_addr; logic [6:0] tx_len; logic [31:0] tx_data;
  logic user_stat_we = 0, user_stat_d = 0, user_stat, signal_detect, own_data_seen;

  int tests = 0, fails = 0;
  int mem_n = 0, tx_n = 0;
  logic [15:0] ml_a [512]; logic [31:0] ml_d [512];
  logic [15:0] tl_a [512]; logic [31:0] tl_d [512]; logic [7:0] tl_o [512];
  logic tl_s [512]; logic tl_e [512]; logic [6:0] tl_l [512];

  ring_mem_node uut (
    .clk(clk), .rst_n(rst_n), .node_id(MY_ID),
    .host_valid(host_valid), .host_ready(host_ready), .host_addr(host_addr), .host_data(host_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
    .rx_origin(rx_origin), .rx_addr(rx_addr), .rx_data(rx_data),
    .link_present(link_present), .link_sync(link_sync),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_origin(tx_origin), .tx_addr(tx_addr), .tx_len(tx_len), .tx_data(tx_data),
    .user_stat_we(user_stat_we), .user_stat_d(user_stat_d), .user_stat(user_stat),
    .signal_detect(signal_detect), .own_data_seen(own_data_seen));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (mem_we && mem_n < 512) begin ml_a[mem_n] = mem_addr; ml_d[mem_n] = mem_data; mem_n++; end
    if (tx_valid && tx_ready && tx_n < 512) begin
      tl_a[tx_n] = tx_addr; tl_d[tx_n] = tx_data; tl_o[tx_n] = tx_origin;
      tl_s[tx_n] = tx_sop; tl_e[tx_n] = tx_eop; tl_l[tx_n] = tx_len; tx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [31:0] d);
    host_valid = 1; host_addr = a; host_data = d;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    @(posedge clk); #1;
    host_valid = 0;
  endtask

  task automatic rx_send(input logic [7:0] org, input logic [15:0] a, input int len, input bit err, input logic [31:0] seed);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_sop = (i == 0); rx_eop = (i == len - 1); rx_err = err && (i == len - 1);
      rx_origin = org; rx_addr = a; rx_data = seed + 32'(i);
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_err = 0;
  endtask

  function automatic logic [31:0] hd(input logic [15:0] a);
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  task automatic flush(input int n);
    tx_ready = 1; cyc(n); tx_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    @(negedge clk);
    chk(user_stat == 1, "R1 user_stat", user_stat, 1);
    chk(own_data_seen == 0, "R1 own_data_seen", own_data_seen, 0);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk(host_ready == 1 && rx_ready == 1, "R1 ready", {host_ready, rx_ready}, 3);
    chk(signal_detect == 1, "R12 signal_detect up", signal_detect, 1);
    @(posedge clk); #1;

    // host write sweep: packet splitting
    for (int n = 1; n <= 20; n++) begin
      logic [15:0] base;
      base = 16'(n * 64);
      mem_n = 0; tx_n = 0;
      for (int i = 0; i < n; i++) host_write(base + 16'(i), hd(base + 16'(i)));
      chk(mem_n == n, "R2 mem write count", mem_n, n);
      for (int i = 0; i < n; i++)
        chk(ml_a[i] == base + 16'(i) && ml_d[i] == hd(base + 16'(i)), "R2 mem write", ml_a[i], base + 16'(i));
      flush(30);
      chk(tx_n == n, "R3 beat count", tx_n, n);
      for (int j = 0; j < n; j++) begin
        int k, rl;
        k = j % 16;
        rl = (n - j) < 16 ? (n - j) : 16;
        chk(tl_s[j] == (k == 0), "R3 sop", tl_s[j], k == 0);
        chk(tl_e[j] == (k == 15 || j == n - 1), "R3 eop", tl_e[j], k == 15 || j == n - 1);
        if (k == 0) chk(tl_l[j] == 7'(rl * 4), "R3 len", tl_l[j], rl * 4);
        chk(tl_d[j] == hd(base + 16'(j)) && tl_a[j] == base + 16'(j) && tl_o[j] == MY_ID,
            "R2 queued word", tl_d[j], hd(base + 16'(j)));
      end
    end

    // gapped addresses split packets
    mem_n = 0; tx_n = 0;
    host_write(16'd10, hd(10)); host_write(16'd11, hd(11));
    host_write(16'd20, hd(20)); host_write(16'd21, hd(21)); host_write(16'd22, hd(22));
    flush(20);
    chk(tx_n == 5, "R3 gap beats", tx_n, 5);
    chk(tl_s[0] && tl_l[0] == 8 && tl_e[1], "R3 gap first pkt", tl_l[0], 8);
    chk(tl_s[2] && tl_l[2] == 12 && tl_e[4], "R3 gap second pkt", tl_l[2], 12);

    // received foreign packets, all lengths
    for (int len = 1; len <= 16; len++) begin
      logic [15:0] base; logic [7:0] org; logic [31:0] seed;
      base = 16'h2000 + 16'(len * 32);
      org = (len % 2) ? 8'd3 : 8'd7;
      seed = 32'h5A00_0000 + 32'(len * 256);
      mem_n = 0; tx_n = 0;
      rx_send(org, base, len, 0, seed);
      cyc(len + 3);
      chk(mem_n == len, "R5 mem count", mem_n, len);
      for (int i = 0; i < len; i++)
        chk(ml_a[i] == base + 16'(i) && ml_d[i] == seed + 32'(i), "R5 mem word", ml_d[i], seed + 32'(i));
      flush(25);
      chk(tx_n == len, "R5 forward count", tx_n, len);
      chk(tl_s[0] && tl_l[0] == 7'(len * 4) && tl_o[0] == org && tl_a[0] == base, "R5 forward header", tl_l[0], len * 4);
      chk(tl_e[len-1], "R5 forward eop", tl_e[len-1], 1);
      for (int i = 0; i < len; i++)
        chk(tl_d[i] == seed + 32'(i) && tl_o[i] == org, "R5 forward word", tl_d[i], seed + 32'(i));
    end

    // error and over-length packets
    mem_n = 0; tx_n = 0; tx_ready = 1;
    rx_send(8'd3, 16'h3000, 4, 1, 32'h1111_0000);
    cyc(10);
    chk(mem_n == 0 && tx_n == 0, "R4 error packet dropped", mem_n + tx_n, 0);
    rx_send(8'd3, 16'h3100, 17, 0, 32'h2222_0000);
    cyc(25);
    chk(mem_n == 0 && tx_n == 0, "R4 over-length dropped", mem_n + tx_n, 0);
    rx_send(8'd3, 16'h3200, 2, 0, 32'h3333_0000);
    cyc(10);
    chk(mem_n == 2 && tx_n == 2, "R4 recovery after drop", mem_n + tx_n, 4);

    // own packet returns
    mem_n = 0; tx_n = 0;
    chk(own_data_seen == 0, "R7 flag clear before", own_data_seen, 0);
    rx_send(MY_ID, 16'h3300, 3, 0, 32'h4444_0000);
    cyc(10);
    chk(mem_n == 0 && tx_n == 0, "R6 own packet removed", mem_n + tx_n, 0);
    chk(own_data_seen == 1, "R7 flag set", own_data_seen, 1);
    rx_send(8'd9, 16'h3400, 1, 0, 32'h5555_0000);
    cyc(10);
    chk(own_data_seen == 1, "R7 flag sticky", own_data_seen, 1);
    tx_ready = 0;

    // forwarding has priority over host
    mem_n = 0; tx_n = 0;
    rx_send(8'd3, 16'h0300, 8, 0, 32'h6666_0000);
    @(negedge clk);
    chk(host_ready == 0 && rx_ready == 0, "R9 host blocked during forward", host_ready, 0);
    @(posedge clk); #1;
    host_write(16'h0308, hd(16'h0308));
    chk(mem_n == 9, "R9 mem count", mem_n, 9);
    chk(ml_a[7] == 16'h0307 && ml_a[8] == 16'h0308 && ml_d[8] == hd(16'h0308), "R9 order", ml_a[8], 16'h0308);
    flush(20);
    chk(tx_n == 9, "R9 beats", tx_n, 9);
    chk(tl_s[0] && tl_l[0] == 32 && tl_o[0] == 8'd3, "R3 forward pkt", tl_l[0], 32);
    chk(tl_s[8] && tl_l[8] == 4 && tl_o[8] == MY_ID, "R3 origin split", tl_o[8], MY_ID);

    // full queue
    mem_n = 0; tx_n = 0;
    for (int i = 0; i < 32; i++) host_write(16'h0400 + 16'(2 * i), hd(16'h0400 + 16'(2 * i)));
    host_valid = 1; host_addr = 16'h0500; host_data = hd(16'h0500);
    @(negedge clk);
    chk(host_ready == 0, "R10 full blocks", host_ready, 0);
    cyc(5);
    @(negedge clk);
    chk(host_ready == 0 && mem_n == 32, "R10 held", mem_n, 32);
    @(posedge clk); #1;
    tx_ready = 1;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    @(posedge clk); #1;
    host_valid = 0;
    cyc(50); tx_ready = 0;
    chk(tx_n == 33, "R10 no loss", tx_n, 33);
    for (int i = 0; i < 32; i++)
      chk(tl_d[i] == hd(16'h0400 + 16'(2 * i)), "R10 order", tl_d[i], hd(16'h0400 + 16'(2 * i)));
    chk(tl_d[32] == hd(16'h0500), "R10 held word", tl_d[32], hd(16'h0500));

    // link loss
    mem_n = 0; tx_n = 0;
    link_sync = 0; tx_ready = 1;
    host_write(16'h0600, hd(16'h0600)); host_write(16'h0601, hd(16'h0601)); host_write(16'h0602, hd(16'h0602));
    cyc(20);
    @(negedge clk);
    chk(tx_n == 0 && tx_valid == 0, "R8 no send out of sync", tx_n, 0);
    chk(signal_detect == 1, "R12 detect with signal", signal_detect, 1);
    @(posedge clk); #1;
    link_present = 0; link_sync = 1;
    cyc(5);
    @(negedge clk);
    chk(signal_detect == 0, "R12 detect lost", signal_detect, 0);
    chk(tx_n == 0, "R8 no send without signal", tx_n, 0);
    @(posedge clk); #1;
    link_present = 1;
    cyc(10);
    chk(tx_n == 3 && tl_l[0] == 12, "R8 sent after recovery", tx_n, 3);
    tx_ready = 0;

    // user status
    user_stat_we = 1; user_stat_d = 0; cyc(1); user_stat_we = 0;
    @(negedge clk); chk(user_stat == 0, "R11 write 0", user_stat, 0);
    @(posedge clk); #1; user_stat_d = 1; cyc(2);
    @(negedge clk); chk(user_stat == 0, "R11 hold without strobe", user_stat, 0);
    @(posedge clk); #1; user_stat_we = 1; cyc(1); user_stat_we = 0;
    @(negedge clk); chk(user_stat == 1, "R11 write 1", user_stat, 1);

    // reset clears own flag
    @(posedge clk); #1; rst_n = 0; cyc(2); rst_n = 1;
    @(negedge clk);
    chk(own_data_seen == 0 && user_stat == 1, "R1 reset again", own_data_seen, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule